// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

The block turns a two-part logical address into a physical address. The two parts are a segment number and an offset within that segment. A small table held in registers describes each segment with a base address and a limit. The offset must be strictly smaller than the limit; only then is the base added to it to form the physical address. A separate length register states how many table entries are in use. A segment number at or above that count is illegal. Either violation produces a trap with a cause code, and no address is given out.

Software loads table entries through a write port that carries an index, a base and a limit. It sets the length register through its own strobe. Both kinds of write take effect in the cycle after the strobe. The unit accepts one request every cycle and returns each result from output registers one cycle later. After reset the length register is zero, so every access traps until the table has been set up.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset `rsp_valid` and `rsp_trap` are 0 and the length register is 0, so any request issued before a length write returns a trap with cause 0.
- R2: A request sampled with `req_valid` high at a clock edge produces `rsp_valid` high after exactly that edge, for one cycle per request. Back-to-back requests give back-to-back responses. `rsp_valid` is low after an edge at which `req_valid` was low.
- R3: When the segment number is below the length register and the offset is below the segment's limit, `rsp_trap` is 0 and `rsp_addr` is (base + offset) modulo 2^PA_W.
- R4: When the segment number is legal but the offset is greater than or equal to the segment's limit, `rsp_trap` is 1, `rsp_cause` is 1 (limit fault) and `rsp_addr` is 0. A limit of 0 makes every offset fault.
- R5: When the segment number is greater than or equal to the length register, `rsp_trap` is 1, `rsp_cause` is 0 (segment fault) and `rsp_addr` is 0. This cause takes priority over a limit fault.
- R6: A table write with `tbl_we` high takes effect for requests sampled at later edges. A request sampled at the same edge as the write is translated with the old entry. Entries other than the one indexed keep their contents.
- R7: A length write with `len_we` high follows the same timing: a request at the same edge is checked against the old length, and later requests against the new one.
- R8: Whenever `rsp_valid` is 0, `rsp_trap`, `rsp_cause` and `rsp_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_seg | input | SEG_W | Segment number of the request |
| req_off | input | OFF_W | Offset within the segment |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | SEG_W | Entry index to write |
| tbl_base | input | PA_W | Base address to store |
| tbl_limit | input | OFF_W+1 | Segment limit to store (legal offsets are below it) |
| len_we | input | 1 | Length register write strobe |
| len_val | input | SEG_W+1 | Number of legal segments |
| rsp_valid | output | 1 | Registered result present |
| rsp_trap | output | 1 | Request faulted; no address given |
| rsp_cause | output | 1 | 0 = segment number fault, 1 = offset limit fault |
| rsp_addr | output | PA_W | Physical address, 0 on trap |

## Verification
The bench first translates offsets below the limit, including a base close to the top of the physical space, so that the addition and its wrap-around are checked apart from the bounds logic. It then places offsets exactly at the limit, one below it and against a zero limit, which separates strict from non-strict comparison. Segment numbers at and beyond the length register, some paired with a bad offset, show whether the segment-number fault is kept apart from the limit fault and given priority. Writes issued in the same cycle as a request, followed by a repeat of that request, show whether a request sees old or new table and length contents. Back-to-back requests and idle cycles show the one-cycle latency and the zeroed outputs.

// File: rtl/segxl_pkg.sv
package segxl_pkg;

    typedef enum logic {
        CAUSE_SEG = 1'b0,
        CAUSE_LIM = 1'b1
    } fault_e;

    typedef struct packed {
        logic   trap;
        fault_e cause;
    } verdict_t;

    // segment-number fault outranks offset fault
    function automatic verdict_t judge(input logic seg_ok, input logic off_ok);
        verdict_t v;
        v.trap  = !(seg_ok && off_ok);
        v.cause = seg_ok ? CAUSE_LIM : CAUSE_SEG;
        return v;
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W  = 3,
    parameter int BASE_W = 20,
    parameter int LIM_W  = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic              len_wr,
    input  logic [SEG_W:0]    len_in,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic [SEG_W:0]    len_q
);
    localparam int NSEG = 1 << SEG_W;

    logic [BASE_W-1:0] base_q  [NSEG];
    logic [LIM_W-1:0]  limit_q [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[i]  <= '0;
                limit_q[i] <= '0;
            end else if (wr_en && (wr_idx == SEG_W'(i))) begin
                base_q[i]  <= wr_base;
                limit_q[i] <= wr_limit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            len_q <= '0;
        else if (len_wr)
            len_q <= len_in;
    end

    assign rd_base  = base_q[rd_idx];
    assign rd_limit = limit_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
    import segxl_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W:0]   limit,
    input  logic [SEG_W:0]   len,
    output verdict_t         verdict,
    output logic [PA_W-1:0]  addr
);
    localparam int PAD_W = PA_W - OFF_W;

    logic seg_ok;
    logic off_ok;

    always_comb begin
        seg_ok  = {1'b0, seg} < len;
        off_ok  = {1'b0, off} < limit;
        verdict = judge(seg_ok, off_ok);
        addr    = base + {{PAD_W{1'b0}}, off};
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import segxl_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic             tbl_we,
    input  logic [SEG_W-1:0] tbl_idx,
    input  logic [PA_W-1:0]  tbl_base,
    input  logic [OFF_W:0]   tbl_limit,
    input  logic             len_we,
    input  logic [SEG_W:0]   len_val,
    output logic             rsp_valid,
    output logic             rsp_trap,
    output logic             rsp_cause,
    output logic [PA_W-1:0]  rsp_addr
);
    localparam int LIM_W = OFF_W + 1;

    logic [PA_W-1:0]  ent_base;
    logic [LIM_W-1:0] ent_limit;
    logic [SEG_W:0]   len_q;
    verdict_t         verdict;
    logic [PA_W-1:0]  sum_addr;

    seg_table #(.SEG_W(SEG_W), .BASE_W(PA_W), .LIM_W(LIM_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_base  (tbl_base),
        .wr_limit (tbl_limit),
        .len_wr   (len_we),
        .len_in   (len_val),
        .rd_idx   (req_seg),
        .rd_base  (ent_base),
        .rd_limit (ent_limit),
        .len_q    (len_q)
    );

    seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .seg     (req_seg),
        .off     (req_off),
        .base    (ent_base),
        .limit   (ent_limit),
        .len     (len_q),
        .verdict (verdict),
        .addr    (sum_addr)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_trap  <= 1'b0;
            rsp_cause <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_trap  <= verdict.trap;
            rsp_cause <= verdict.trap ? logic'(verdict.cause) : 1'b0;
            rsp_addr  <= verdict.trap ? '0 : sum_addr;
        end
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [SEG_W-1:0] req_seg,
    input logic [OFF_W-1:0] req_off,
    input logic [OFF_W:0]   ent_limit,
    input logic [SEG_W:0]   len_q,
    input logic             rsp_valid,
    input logic             rsp_trap,
    input logic             rsp_cause,
    input logic [PA_W-1:0]  rsp_addr
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !rsp_valid && !rsp_trap);

    // R2
    latency_one_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R5
    seg_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ({1'b0, req_seg} >= len_q)) |=> (rsp_trap && !rsp_cause));

    // R4
    lim_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ({1'b0, req_seg} < len_q) && ({1'b0, req_off} >= ent_limit))
        |=> (rsp_trap && rsp_cause && rsp_addr == '0));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_trap && !rsp_cause && rsp_addr == '0));

endmodule

bind seg_xlate_unit seg_xlate_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_seg   (req_seg),
    .req_off   (req_off),
    .ent_limit (ent_limit),
    .len_q     (len_q),
    .rsp_valid (rsp_valid),
    .rsp_trap  (rsp_trap),
    .rsp_cause (rsp_cause),
    .rsp_addr  (rsp_addr)
);

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;
    localparam int SEG_W = 3;
    localparam int OFF_W = 16;
    localparam int PA_W  = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic             tbl_we = 1'b0;
    logic [SEG_W-1:0] tbl_idx = '0;
    logic [PA_W-1:0]  tbl_base = '0;
    logic [OFF_W:0]   tbl_limit = '0;
    logic             len_we = 1'b0;
    logic [SEG_W:0]   len_val = '0;
    logic             rsp_valid;
    logic             rsp_trap;
    logic             rsp_cause;
    logic [PA_W-1:0]  rsp_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    seg_xlate_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_seg_xlate_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .len_we(len_we), .len_val(len_val), .rsp_valid(rsp_valid), .rsp_trap(rsp_trap),
        .rsp_cause(rsp_cause), .rsp_addr(rsp_addr)
    );

    task automatic expect_rsp(input string req, input logic v, input logic t,
                              input logic c, input logic [PA_W-1:0] a);
        checks++;
        if (rsp_valid !== v || rsp_trap !== t || rsp_cause !== c || rsp_addr !== a) begin
            errors++;
            $display("FAIL %s: got v=%0b t=%0b c=%0b a=%0d, expected v=%0b t=%0b c=%0b a=%0d",
                     req, rsp_valid, rsp_trap, rsp_cause, rsp_addr, v, t, c, a);
        end
    endtask

    // inputs change at negedge, results sampled at the following negedge
    task automatic write_entry(input int idx, input int base, input int limit);
        tbl_we = 1'b1; tbl_idx = SEG_W'(idx);
        tbl_base = PA_W'(base); tbl_limit = (OFF_W+1)'(limit);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic write_len(input int n);
        len_we = 1'b1; len_val = (SEG_W+1)'(n);
        @(negedge clk);
        len_we = 1'b0;
    endtask

    task automatic xlate(input string req, input int seg, input int off,
                         input logic t, input logic c, input int a);
        req_valid = 1'b1; req_seg = SEG_W'(seg); req_off = OFF_W'(off);
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp(req, 1'b1, t, c, PA_W'(a));
    endtask

    task automatic t_reset;
        expect_rsp("R1 reset outputs", 1'b0, 1'b0, 1'b0, '0);
        xlate("R1 access before length write", 0, 0, 1'b1, 1'b0, 0);
        @(negedge clk);
        expect_rsp("R8 idle after request", 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_translate;
        write_len(3);
        write_entry(0, 14000, 1000);
        write_entry(1, (1 << PA_W) - 4, 100);
        write_entry(2, 100, 0);
        xlate("R3 base 14000 offset 346", 0, 346, 1'b0, 1'b0, 14346);
        xlate("R3 offset one below limit", 0, 999, 1'b0, 1'b0, 14999);
        xlate("R3 wrap of sum", 1, 10, 1'b0, 1'b0, 6);
        xlate("R6 other entry kept", 0, 0, 1'b0, 1'b0, 14000);
    endtask

    task automatic t_limits;
        xlate("R4 offset equal to limit", 0, 1000, 1'b1, 1'b1, 0);
        xlate("R4 offset far above limit", 1, 65535, 1'b1, 1'b1, 0);
        xlate("R4 zero limit", 2, 0, 1'b1, 1'b1, 0);
    endtask

    task automatic t_segfault;
        xlate("R5 segment equal to length", 3, 0, 1'b1, 1'b0, 0);
        xlate("R5 top segment", 7, 5, 1'b1, 1'b0, 0);
        write_len(2);
        xlate("R5 priority over limit fault", 2, 0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_same_cycle;
        // table write together with a request: old entry used
        tbl_we = 1'b1; tbl_idx = 0; tbl_base = PA_W'(5000); tbl_limit = 17'd50;
        req_valid = 1'b1; req_seg = 0; req_off = 16'd1;
        @(negedge clk);
        tbl_we = 1'b0; req_valid = 1'b0;
        expect_rsp("R6 request with write uses old entry", 1'b1, 1'b0, 1'b0, PA_W'(14001));
        xlate("R6 new entry after write", 0, 1, 1'b0, 1'b0, 5001);
        xlate("R6 new limit applies", 0, 50, 1'b1, 1'b1, 0);
        // length write together with a request: old length used
        write_entry(2, 100, 10);
        len_we = 1'b1; len_val = 4'd3;
        req_valid = 1'b1; req_seg = 2; req_off = 16'd4;
        @(negedge clk);
        len_we = 1'b0; req_valid = 1'b0;
        expect_rsp("R7 request with length write uses old length", 1'b1, 1'b1, 1'b0, '0);
        xlate("R7 new length after write", 2, 4, 1'b0, 1'b0, 104);
    endtask

    task automatic t_stream;
        req_valid = 1'b1; req_seg = 0; req_off = 16'd7;
        @(negedge clk);
        expect_rsp("R2 first of back-to-back", 1'b1, 1'b0, 1'b0, PA_W'(5007));
        req_seg = 2; req_off = 16'd9;
        @(negedge clk);
        expect_rsp("R2 second of back-to-back", 1'b1, 1'b0, 1'b0, PA_W'(109));
        req_valid = 1'b0;
        @(negedge clk);
        expect_rsp("R2 no response without request", 1'b0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_translate();
        t_limits();
        t_segfault();
        t_same_cycle();
        t_stream();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule